// File: doc/BRIEF.md
# Serial 1001 Pattern Detector (Non-Overlapping)

This block watches a single serial bit stream, one bit per clock, and raises a one-cycle detect pulse each time the four-bit pattern one, zero, zero, one has just been completed. Matches do not overlap. Once a match is reported, every bit that formed it is spent. A new match must start from a fresh leading one that arrives after the match.

The controller is a five-state Moore machine. Its states and their binary codes are:

- `ST_IDLE` = 0
- `ST_ONE` = 1
- `ST_ONE_ZERO` = 2
- `ST_ONE_ZERO_ZERO` = 3
- `ST_MATCH` = 4

The state bits are held in toggle-type flip-flops. The next-state logic therefore produces, for each bit, an enable that says whether that bit flips. A synchronous active-high reset clears the toggle flops.

The transitions are:

- `ST_IDLE`: a one goes to `ST_ONE`; a zero stays in `ST_IDLE`.
- `ST_ONE`: a one stays in `ST_ONE`; a zero goes to `ST_ONE_ZERO`.
- `ST_ONE_ZERO`: a one goes back to `ST_ONE`; a zero goes to `ST_ONE_ZERO_ZERO`.
- `ST_ONE_ZERO_ZERO`: a one goes to `ST_MATCH`; a zero goes to `ST_IDLE`.
- `ST_MATCH`: a one goes to `ST_ONE`; a zero goes to `ST_IDLE`.
- Any unused code (5 to 7) goes to `ST_IDLE`.

Top module: `seq1001_detector`

## Requirements
- R1: A synchronous reset held high at a rising clock edge puts the machine in `ST_IDLE` (code 0), with `hit` low. A partial match in progress is discarded, so a final one received after the reset does not complete it.
- R2: `hit` goes high in the clock cycle right after the edge that samples the final one of the sequence 1,0,0,1. This is Moore behaviour: `hit` is decoded only from state `ST_MATCH`.
- R3: Detection does not overlap. A zero in `ST_MATCH` returns to `ST_IDLE`. As a result, the stream 1001001 gives exactly one pulse, after the fourth bit.
- R4: A one in `ST_MATCH` goes to `ST_ONE`. As a result, the stream 10011001 gives two pulses, after bits four and eight.
- R5: A one in `ST_ONE` stays in `ST_ONE`. As a result, the stream 111001 gives one pulse, after the last bit.
- R6: A one in `ST_ONE_ZERO` goes to `ST_ONE`. As a result, the stream 101001 gives one pulse, after the last bit.
- R7: A zero in `ST_ONE_ZERO_ZERO` returns to `ST_IDLE`. As a result, the stream 10001 gives no pulse.
- R8: `hit` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Serial data bit, sampled each rising edge |
| hit | output | 1 | One-cycle pulse when 1001 has just completed |

## Verification
The stream 1001001 separates non-overlapping detection from overlapping detection: an overlapping detector would pulse a second time on the final bit. The stream 10011001 shows that a one arriving right after a match correctly begins a new pattern. The streams 111001, 101001 and 10001 each exercise one fall-back arc inside a partial match: staying on repeated ones, restarting after 1,0,1, and aborting on three zeros. A reset applied in the middle of a partial match checks that the interrupted prefix is thrown away.

// File: rtl/seq1001_pkg.sv
`timescale 1ns/1ps
package seq1001_pkg;
    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE          = 3'd0,
        ST_ONE           = 3'd1,
        ST_ONE_ZERO      = 3'd2,
        ST_ONE_ZERO_ZERO = 3'd3,
        ST_MATCH         = 3'd4
    } det_state_e;
endpackage

// File: rtl/seq1001_toggle_reg.sv
`timescale 1ns/1ps
module seq1001_toggle_reg #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] tog,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_tff
        always_ff @(posedge clk) begin
            if (rst) q[i] <= 1'b0;
            else     q[i] <= q[i] ^ tog[i];
        end
    end
endmodule

// File: rtl/seq1001_next_toggle.sv
`timescale 1ns/1ps
module seq1001_next_toggle
    import seq1001_pkg::*;
(
    input  det_state_e         cur,
    input  logic               din,
    output logic [STATE_W-1:0] tog
);
    det_state_e nxt;

    always_comb begin
        unique case (cur)
            ST_IDLE:          nxt = din ? ST_ONE   : ST_IDLE;
            ST_ONE:           nxt = din ? ST_ONE   : ST_ONE_ZERO;
            ST_ONE_ZERO:      nxt = din ? ST_ONE   : ST_ONE_ZERO_ZERO;
            ST_ONE_ZERO_ZERO: nxt = din ? ST_MATCH : ST_IDLE;
            ST_MATCH:         nxt = din ? ST_ONE   : ST_IDLE;
            default:          nxt = ST_IDLE;
        endcase
    end

    always_comb tog = cur ^ nxt;
endmodule

// File: rtl/seq1001_out_dec.sv
`timescale 1ns/1ps
module seq1001_out_dec
    import seq1001_pkg::*;
(
    input  det_state_e cur,
    output logic       hit
);
    always_comb begin
        unique case (cur)
            ST_MATCH: hit = 1'b1;
            default:  hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/seq1001_detector.sv
`timescale 1ns/1ps
module seq1001_detector
    import seq1001_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic hit
);
    logic [STATE_W-1:0] q;
    logic [STATE_W-1:0] tog;
    det_state_e         cur;

    always_comb cur = det_state_e'(q);

    seq1001_toggle_reg #(.W(STATE_W)) u_reg (
        .clk (clk),
        .rst (rst),
        .tog (tog),
        .q   (q)
    );

    seq1001_next_toggle u_nxt (
        .cur (cur),
        .din (din),
        .tog (tog)
    );

    seq1001_out_dec u_out (
        .cur (cur),
        .hit (hit)
    );

    AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (cur == ST_IDLE) && !hit); // R1
    AST_HIT_AFTER_PATTERN: assert property (@(posedge clk) disable iff (rst)
        hit |-> ($past(cur) == ST_ONE_ZERO_ZERO) && $past(din)); // R2
    AST_MATCH_ZERO_IDLE: assert property (@(posedge clk) disable iff (rst)
        (cur == ST_MATCH && !din) |=> cur == ST_IDLE); // R3
    AST_MATCH_ONE_RESTART: assert property (@(posedge clk) disable iff (rst)
        (cur == ST_MATCH && din) |=> cur == ST_ONE); // R4
    AST_ONE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cur == ST_ONE && din) |=> cur == ST_ONE); // R5
    AST_ONE_ZERO_RESTART: assert property (@(posedge clk) disable iff (rst)
        (cur == ST_ONE_ZERO && din) |=> cur == ST_ONE); // R6
    AST_TRIPLE_ZERO_ABORT: assert property (@(posedge clk) disable iff (rst)
        (cur == ST_ONE_ZERO_ZERO && !din) |=> cur == ST_IDLE); // R7
    AST_HIT_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        hit |=> !hit); // R8
endmodule

// File: tb/sim_seq1001_detector.sv
`timescale 1ns/1ps
module sim_seq1001_detector;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b0;
    logic hit;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    always #2.5 clk = ~clk;

    seq1001_detector u0 (.clk(clk), .rst(rst), .din(din), .hit(hit));

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: hit=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        din = 1'b0;
        @(posedge clk);
        @(posedge clk);
        #1;
        check("R1", hit, 1'b0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // bits and exp are given MSB first; exp holds the hit value after each bit
    task automatic play(input string req, input int n, input logic [15:0] bits,
                        input logic [15:0] exp);
        int hits = 0;
        int exp_hits = 0;
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk);
            din = bits[i];
            @(posedge clk);
            #1;
            check(req, hit, exp[i]);
            if (hit === 1'b1) hits++;
            if (exp[i]) exp_hits++;
        end
        n_chk++;
        if (hits != exp_hits) begin
            n_bad++;
            $display("FAIL %s: pulse count %0d expected %0d", req, hits, exp_hits);
        end
    endtask

    task automatic t_basic();        // R2
        do_reset();
        play("R2", 4, 16'b1001, 16'b0001);
    endtask

    task automatic t_no_overlap();   // R3
        do_reset();
        play("R3", 7, 16'b1001001, 16'b0001000);
    endtask

    task automatic t_back_to_back(); // R4, R8
        do_reset();
        play("R4", 8, 16'b10011001, 16'b00010001);
        @(negedge clk);
        din = 1'b1;
        @(posedge clk);
        #1;
        check("R8", hit, 1'b0);
    endtask

    task automatic t_many_ones();    // R5
        do_reset();
        play("R5", 6, 16'b111001, 16'b000001);
    endtask

    task automatic t_restart();      // R6
        do_reset();
        play("R6", 6, 16'b101001, 16'b000001);
    endtask

    task automatic t_abort();        // R7
        do_reset();
        play("R7", 5, 16'b10001, 16'b00000);
    endtask

    task automatic t_mid_reset();    // R1
        do_reset();
        play("R1", 3, 16'b100, 16'b000);
        do_reset();
        play("R1", 1, 16'b1, 16'b0);
    endtask

    initial begin
        do_reset();
        t_basic();
        t_no_overlap();
        t_back_to_back();
        t_many_ones();
        t_restart();
        t_abort();
        t_mid_reset();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule